// File: doc/BRIEF.md
# Clock Output Pin Function Selector

This block drives one multi-purpose output pin from a 12 MHz reference clock. An 8-bit control register picks what the pin carries. It can carry a power-of-two division of the reference, an active-low enable for a power amplifier, a serial radio data stream, or a static level that software supplies. In serial-stream mode with the SPI port wired for three-wire operation, the bit clock of the stream is also steered onto the SPI data-out pin.

The same register holds an enable for a crystal-ready interrupt. With the enable set, a crystal-stable pulse after wake-up latches a pending event that drives the interrupt line. A register write that clears the enable bit also clears the event. Software silences the pin by selecting the static-level mode and holding the level input constant.

Register layout: bits 7:6 select the function (00 divided clock, 01 amplifier control, 10 serial stream, 11 static level). Bit 5 is the interrupt enable. Bits 4:3 are unused and read as zero. Bits 2:0 hold the frequency code.

Top module: `clkpin_sel`

## Requirements
- R1: After reset the register reads 0x04, the interrupt is low, the pin is low and the SPI clock output and its enable are low.
- R2: A write stores bits 7:6, 5 and 2:0; bits 4:3 always read back as zero, so a read returns the written value ANDed with 0xE7.
- R3: With function 00 and frequency code c from 1 to 4, the pin equals bit c-1 of a counter that is cleared by reset and advances on every reference edge. This gives a 50% duty clock of period 2^c reference cycles (6, 3, 1.5, 0.75 MHz).
- R4: With function 00 and code 0, the pin follows the reference clock itself (12 MHz).
- R5: With function 00 and codes 5 to 7, the pin holds low.
- R6: With function 01, the pin is low while the amplifier-on input is high and high otherwise.
- R7: With function 10, the pin follows the serial data input. The SPI clock output follows the serial bit clock and its enable is high only when the three-wire flag is also high; in every other case both are low.
- R8: With function 11, the pin follows the static level input.
- R9: With bit 5 set, a crystal-stable pulse raises the interrupt on the next edge, and it stays high until cleared.
- R10: A crystal-stable pulse while bit 5 is clear is ignored and is not remembered when bit 5 is later set.
- R11: A write with bit 5 clear drops a pending interrupt on the next edge. A write with bit 5 set keeps it, and a clearing write wins over a pulse in the same cycle.
- R12: Changing the function or frequency code does not restart the divider counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 12 MHz reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| pa_on_i | input | 1 | Power amplifier on request |
| ser_data_i | input | 1 | Serial radio data stream |
| ser_clk_i | input | 1 | Bit clock of the serial stream |
| gpio_lvl_i | input | 1 | Static level for the pin |
| spi3w_i | input | 1 | SPI port is in three-wire mode |
| xtal_ok_i | input | 1 | Crystal-stable pulse after wake-up |
| pin_o | output | 1 | Multi-purpose pin level |
| miso_clk_o | output | 1 | Serial clock for the SPI data-out pin |
| miso_clk_en_o | output | 1 | Selects miso_clk_o onto the SPI data-out pin |
| irq_o | output | 1 | Crystal-stable interrupt |

## Verification
The register is swept over all 256 write values, so that stored bits can be told apart from unused bits. Every divider code is held for many cycles, and the pin is compared with a cycle count taken since reset. This separates a wrong tap, a restarted counter and a stuck output, and the counter is kept running across mode switches. The serial mode is driven with all eight combinations of data, bit clock and three-wire flag, which tells the pin path from the SPI clock path. The interrupt is exercised with pulses while enabled and while disabled, with clearing and non-clearing writes, and with a pulse that coincides with a clearing write.

// File: rtl/clkpin_pkg.sv
package clkpin_pkg;
    localparam int FREQ_W = 3;
    localparam int REG_W  = 8;

    typedef enum logic [1:0] {
        FN_DIV  = 2'b00,
        FN_PA_N = 2'b01,
        FN_SER  = 2'b10,
        FN_GPIO = 2'b11
    } pin_fn_e;

    typedef struct packed {
        pin_fn_e           fn;
        logic              irq_en;
        logic [FREQ_W-1:0] freq;
        logic              pend;
    } ctl_s;
endpackage

// File: rtl/clkpin_regs.sv
module clkpin_regs
    import clkpin_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic              xtal_ok_i,
    output pin_fn_e           fn_o,
    output logic [FREQ_W-1:0] freq_o,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              irq_o
);
    localparam logic [FREQ_W-1:0] FREQ_RST = FREQ_W'(4);

    ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.irq_en && xtal_ok_i) begin
            ctl_d.pend = 1'b1;
        end
        if (wr_en_i) begin
            ctl_d.fn     = pin_fn_e'(wr_data_i[7:6]);
            ctl_d.irq_en = wr_data_i[5];
            ctl_d.freq   = wr_data_i[FREQ_W-1:0];
            if (!wr_data_i[5]) begin
                ctl_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{fn: FN_DIV, irq_en: 1'b0, freq: FREQ_RST, pend: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign fn_o      = ctl_q.fn;
    assign freq_o    = ctl_q.freq;
    assign irq_o     = ctl_q.pend;
    assign rd_data_o = {ctl_q.fn, ctl_q.irq_en, 2'b00, ctl_q.freq};
endmodule

// File: rtl/clkpin_div.sv
module clkpin_div
    import clkpin_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [FREQ_W-1:0] freq_i,
    output logic              div_o
);
    logic [STAGES-1:0] cnt_d, cnt_q;
    logic [STAGES:0]   tap;

    assign tap[0] = clk_i;

    for (genvar k = 1; k <= STAGES; k++) begin : g_tap
        assign tap[k] = cnt_q[k-1];
    end

    always_comb begin
        cnt_d = cnt_q + STAGES'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        div_o = 1'b0;
        for (int k = 0; k <= STAGES; k++) begin
            if (int'(freq_i) == k) begin
                div_o = tap[k];
            end
        end
    end
endmodule

// File: rtl/clkpin_mux.sv
module clkpin_mux
    import clkpin_pkg::*;
(
    input  pin_fn_e fn_i,
    input  logic    div_i,
    input  logic    pa_on_i,
    input  logic    ser_data_i,
    input  logic    ser_clk_i,
    input  logic    gpio_lvl_i,
    input  logic    spi3w_i,
    output logic    pin_o,
    output logic    miso_clk_o,
    output logic    miso_clk_en_o
);
    always_comb begin
        miso_clk_o    = 1'b0;
        miso_clk_en_o = 1'b0;
        unique case (fn_i)
            FN_DIV:  pin_o = div_i;
            FN_PA_N: pin_o = ~pa_on_i;
            FN_SER: begin
                pin_o         = ser_data_i;
                miso_clk_en_o = spi3w_i;
                miso_clk_o    = spi3w_i & ser_clk_i;
            end
            default: pin_o = gpio_lvl_i;
        endcase
    end
endmodule

// File: rtl/clkpin_sel.sv
module clkpin_sel
    import clkpin_pkg::*;
#(
    parameter int DIV_STAGES = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    input  logic       pa_on_i,
    input  logic       ser_data_i,
    input  logic       ser_clk_i,
    input  logic       gpio_lvl_i,
    input  logic       spi3w_i,
    input  logic       xtal_ok_i,
    output logic       pin_o,
    output logic       miso_clk_o,
    output logic       miso_clk_en_o,
    output logic       irq_o
);
    pin_fn_e           fn;
    logic [FREQ_W-1:0] freq;
    logic              div;

    clkpin_regs u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .xtal_ok_i (xtal_ok_i),
        .fn_o      (fn),
        .freq_o    (freq),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o)
    );

    clkpin_div #(.STAGES(DIV_STAGES)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .freq_i (freq),
        .div_o  (div)
    );

    clkpin_mux u_mux (
        .fn_i          (fn),
        .div_i         (div),
        .pa_on_i       (pa_on_i),
        .ser_data_i    (ser_data_i),
        .ser_clk_i     (ser_clk_i),
        .gpio_lvl_i    (gpio_lvl_i),
        .spi3w_i       (spi3w_i),
        .pin_o         (pin_o),
        .miso_clk_o    (miso_clk_o),
        .miso_clk_en_o (miso_clk_en_o)
    );
endmodule

// File: rtl/clkpin_sel_chk.sv
module clkpin_sel_chk #(
    parameter int DIV_STAGES = 4
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] rd_data_o,
    input logic       pa_on_i,
    input logic       spi3w_i,
    input logic       xtal_ok_i,
    input logic       pin_o,
    input logic       miso_clk_o,
    input logic       irq_o
);
    logic armed_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    a_r3_fast_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && rd_data_o == 8'h01 && $past(rd_data_o) == 8'h01
        |-> pin_o != $past(pin_o));

    a_r5_undef_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[7:6] == 2'b00 && int'(rd_data_o[2:0]) > DIV_STAGES |-> !pin_o);

    a_r6_pa_inverted: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[7:6] == 2'b01 |-> pin_o == !pa_on_i);

    a_r7_miso_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        miso_clk_o |-> rd_data_o[7:6] == 2'b10 && spi3w_i);

    a_r9_irq_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o && !(wr_en_i && !wr_data_i[5]) |=> irq_o);

    a_r10_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(xtal_ok_i) && $past(rd_data_o[5]));

    a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && !wr_data_i[5] |=> !irq_o);
endmodule

bind clkpin_sel clkpin_sel_chk #(.DIV_STAGES(DIV_STAGES)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .pa_on_i   (pa_on_i),
    .spi3w_i   (spi3w_i),
    .xtal_ok_i (xtal_ok_i),
    .pin_o     (pin_o),
    .miso_clk_o(miso_clk_o),
    .irq_o     (irq_o)
);

// File: tb/clkpin_sel_tb_top.sv
module clkpin_sel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       pa_on = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_clk = 1'b0;
    logic       gpio_lvl = 1'b0;
    logic       spi3w = 1'b0;
    logic       xtal_ok = 1'b0;
    logic       pin;
    logic       miso_clk;
    logic       miso_en;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int ncyc   = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

    clkpin_sel dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wr_en_i      (wr_en),
        .wr_data_i    (wr_data),
        .rd_data_o    (rd_data),
        .pa_on_i      (pa_on),
        .ser_data_i   (ser_data),
        .ser_clk_i    (ser_clk),
        .gpio_lvl_i   (gpio_lvl),
        .spi3w_i      (spi3w),
        .xtal_ok_i    (xtal_ok),
        .pin_o        (pin),
        .miso_clk_o   (miso_clk),
        .miso_clk_en_o(miso_en),
        .irq_o        (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 rd", rd_data, 8'h04);
        chk("R1 irq", irq, 0);
        chk("R1 pin", pin, 0);
        chk("R1 miso", {miso_clk, miso_en}, 0);

        // R2 exhaustive write sweep
        for (int v = 0; v < 256; v++) begin
            wr(8'(v));
            chk("R2 readback", rd_data, v & 8'hE7);
        end
        chk("R2 irq untouched", irq, 0);

        // R3 / R12 divided clock codes 1..4, counter never restarts
        for (int c = 1; c <= 4; c++) begin
            wr(8'(c));
            for (int i = 0; i < 40; i++) begin
                @(negedge clk); #1;
                chk("R3 R12 divided pin", pin, (ncyc >> (c - 1)) & 1);
            end
        end

        // R4 code 0 passes the reference clock
        wr(8'h00);
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #5;
            chk("R4 pin high phase", pin, 1);
            @(negedge clk); #5;
            chk("R4 pin low phase", pin, 0);
        end

        // R5 undefined codes hold low
        for (int c = 5; c <= 7; c++) begin
            wr(8'(c));
            for (int i = 0; i < 20; i++) begin
                @(negedge clk); #1;
                chk("R5 undefined low", pin, 0);
            end
        end

        // R6 amplifier control
        wr(8'h41);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pa_on = i[0];
            #1;
            chk("R6 pa control", pin, !i[0]);
        end
        pa_on = 1'b0;

        // R7 serial stream, all input combinations
        wr(8'h82);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            {spi3w, ser_clk, ser_data} = 3'(i);
            #1;
            chk("R7 ser pin", pin, i & 1);
            chk("R7 miso clk", miso_clk, ((i >> 1) & 1) & ((i >> 2) & 1));
            chk("R7 miso en", miso_en, (i >> 2) & 1);
        end
        wr(8'h01);
        @(negedge clk); #1;
        chk("R7 miso off outside serial", {miso_clk, miso_en}, 0);
        {spi3w, ser_clk, ser_data} = 3'b000;

        // R8 static level
        wr(8'hC3);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            gpio_lvl = i[0];
            #1;
            chk("R8 gpio level", pin, i & 1);
        end
        gpio_lvl = 1'b0;

        // R9 interrupt raise and hold
        wr(8'h20);
        chk("R9 idle", irq, 0);
        @(negedge clk); xtal_ok = 1'b1;
        @(negedge clk); xtal_ok = 1'b0; #1;
        chk("R9 raised", irq, 1);
        repeat (5) @(negedge clk);
        #1;
        chk("R9 held", irq, 1);

        // R11 write keeping enable holds, write clearing enable drops
        wr(8'h24);
        chk("R11 kept", irq, 1);
        wr(8'h04);
        chk("R11 cleared", irq, 0);

        // R10 pulse while disabled is ignored
        @(negedge clk); xtal_ok = 1'b1;
        @(negedge clk); xtal_ok = 1'b0; #1;
        chk("R10 ignored", irq, 0);
        wr(8'h20);
        chk("R10 not remembered", irq, 0);

        // R11 clear wins over a simultaneous pulse
        @(negedge clk);
        xtal_ok = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        xtal_ok = 1'b0; wr_en = 1'b0; #1;
        chk("R11 clear wins", irq, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule